// File: doc/BRIEF.md
# Dual-Bus Synchronous Parity SRAM

This block is a synchronous static memory of 9-bit words with two separate data ports. One port faces a processor bus and the other faces a system bus. Bit 8 of each word is carried as a parity bit and is stored without change. Each cycle, a decode of the selection, the write enable, the two per-port input enables and the two per-port output enables chooses one operation: a read to one or both ports, a write from one port, a write that also streams the written word to the other port, a stream-only transfer with no array cycle, or no operation. Each tri-state port is modelled as a data-out bus and a drive strobe.

The address and both chip selects are captured on the falling clock edge. The write enable, the input enables and both ports' input data are captured on the rising edge. An access launched at a rising edge presents its word during the clock-high phase that follows, through a port latch that is open while the clock is high and closed while it is low. Writes land in the array at the next falling edge. The word on the internal bus is exported together with a valid strobe, so that a separate parity checker can sample it. Any control combination in which a port would drive the bus it is also receiving from is refused, and it raises a sticky error flag.

The depth is 2^ADDR_W words. The full device size corresponds to ADDR_W = 15. The default of 10 keeps the model small.

Top module: `dbsram_top`

## Requirements
- R1: The array stores 2^ADDR_W words of DATA_W (9) bits, with bit 8 as the parity bit. A word written to any address, including address 0 and the highest address, reads back unchanged.
- R2: The address and both chip selects are captured on the falling edge. The write enable, input enables and port input data are captured on the rising edge. An access driven during one high phase presents its data in the following high phase, and back-to-back accesses pipeline at one per cycle.
- R3: The block is selected only when sel_n = 0 and sel = 1 at the capturing falling edge. While it is deselected, neither port drives, ibus_vld is 0 and nothing is written.
- R4: With we_n = 1 and both input enables high, the word at the captured address is driven on each port whose output enable is low, and on no other port.
- R5: With we_n = 0 and exactly one input enable low, the input-register word of that port is written to the captured address.
- R6: When both input enables are low (with either value of we_n), or when we_n = 0 with both input enables high, no write occurs and neither port drives.
- R7: A port whose input enable was captured low never drives, whatever its output enable does.
- R8: When exactly one input enable is low, the other port drives the captured input word while its output enable is low. This holds both with a write (we_n = 0) and without one (we_n = 1, where the array is left unchanged).
- R9: Output enables act asynchronously. A port's drive strobe follows its output enable within a clock phase, with no clock edge in between.
- R10: If a port's input enable is low and its own output enable is also low at the capturing rising edge, the cycle is refused. Neither port drives and nothing is written. mode_err is set and stays set until reset.
- R11: ibus_vld is 1 for a write, a stream, and a read with at least one output enable low. ibus then carries the moved word, and every driving port outputs that same word.
- R12: After reset, neither port drives, ibus_vld is 0 and mode_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, captured on the falling edge |
| sel_n | input | 1 | Active-low chip select, captured on the falling edge |
| sel | input | 1 | Active-high chip select, captured on the falling edge |
| we_n | input | 1 | Active-low write enable, captured on the rising edge |
| p_ie_n | input | 1 | Processor-port input enable, active low, captured on the rising edge |
| s_ie_n | input | 1 | System-port input enable, active low, captured on the rising edge |
| p_oe_n | input | 1 | Processor-port output enable, active low, asynchronous |
| s_oe_n | input | 1 | System-port output enable, active low, asynchronous |
| p_din | input | DATA_W | Processor-port input word |
| s_din | input | DATA_W | System-port input word |
| p_dout | output | DATA_W | Processor-port output latch |
| p_drive | output | 1 | Processor port drives p_dout when 1 |
| s_dout | output | DATA_W | System-port output latch |
| s_drive | output | 1 | System port drives s_dout when 1 |
| ibus | output | DATA_W | Internal bus word, for the parity checker |
| ibus_vld | output | 1 | ibus carries a moved word |
| mode_err | output | 1 | Sticky flag for a refused contention combination |

## Verification
The hardest situation to reach is an output enable that changes in the middle of a clock-high phase. A read is launched, its outputs are checked, and then the processor output enable is inverted with no clock edge in between, and the drive strobe is checked again. A second hard situation is a refused combination that would otherwise write. The bench issues a source-port write with that port's own output enable low, then reads the target address back to prove that the array was left unchanged, while mode_err has to stay set through the later legal cycles.

// File: rtl/dbsram_pkg.sv
// Shared types for the dual-bus SRAM: the decoded operation and the source
// that drives the internal bus. Assumes the users import it.
package dbsram_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_STREAM = 3'd3,
        OP_BAD    = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_PPORT = 2'd2,
        SRC_SPORT = 2'd3
    } src_e;

endpackage

// File: rtl/dbsram_capture.sv
// Input capture for the dual-bus SRAM. Address and chip selects are taken on
// the falling edge. Write enable, input enables and port data are taken on
// the rising edge. A contention combination (a port whose input enable is low
// while its own output enable is also low) is judged at the rising edge and
// kept in a sticky flag. Assumes a synchronous active-low reset on both edges.
module dbsram_capture #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              we_n,
    input  logic              p_ie_n,
    input  logic              s_ie_n,
    input  logic              p_oe_n,
    input  logic              s_oe_n,
    input  logic [DATA_W-1:0] p_din,
    input  logic [DATA_W-1:0] s_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sel_q,
    output logic              we_n_q,
    output logic              p_ie_n_q,
    output logic              s_ie_n_q,
    output logic [DATA_W-1:0] p_din_q,
    output logic [DATA_W-1:0] s_din_q,
    output logic              bad_q,
    output logic              mode_err
);

    logic bad_now;

    // Contention check: exactly one port receives, and that port is also told to drive.
    assign bad_now = sel_q && (p_ie_n ^ s_ie_n) &&
                     ((!p_ie_n && !p_oe_n) || (!s_ie_n && !s_oe_n));

    // Falling edge: hold the address and the combined chip selection.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            addr_q <= addr;
            sel_q  <= !sel_n && sel;
        end
    end

    // Rising edge: hold the controls, the port data and the refusal decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n_q   <= 1'b1;
            p_ie_n_q <= 1'b1;
            s_ie_n_q <= 1'b1;
            p_din_q  <= '0;
            s_din_q  <= '0;
            bad_q    <= 1'b0;
            mode_err <= 1'b0;
        end else begin
            we_n_q   <= we_n;
            p_ie_n_q <= p_ie_n;
            s_ie_n_q <= s_ie_n;
            p_din_q  <= p_din;
            s_din_q  <= s_din;
            bad_q    <= bad_now;
            mode_err <= mode_err || bad_now;
        end
    end

endmodule

// File: rtl/dbsram_decode.sv
// Operation decode for the dual-bus SRAM. It maps the captured controls and
// the live output enables to an operation, an internal-bus source, a write
// strobe, port latch loads and port drive strobes. Purely combinational; the
// output enables are asynchronous by design.
module dbsram_decode
    import dbsram_pkg::*;
(
    input  logic sel_q,
    input  logic bad_q,
    input  logic we_n_q,
    input  logic p_ie_n_q,
    input  logic s_ie_n_q,
    input  logic p_oe_n,
    input  logic s_oe_n,
    output op_e  op,
    output src_e src,
    output logic wr_en,
    output logic p_load,
    output logic s_load,
    output logic p_drive,
    output logic s_drive,
    output logic bus_vld
);

    // Decode one cycle's operation from the held controls.
    always_comb begin
        op      = OP_IDLE;
        src     = SRC_NONE;
        wr_en   = 1'b0;
        p_load  = 1'b0;
        s_load  = 1'b0;
        p_drive = 1'b0;
        s_drive = 1'b0;
        bus_vld = 1'b0;
        if (!sel_q) begin
            op = OP_IDLE;
        end else if (bad_q) begin
            op = OP_BAD;
        end else if (p_ie_n_q && s_ie_n_q) begin
            if (we_n_q) begin
                op      = OP_READ;
                src     = SRC_ARRAY;
                p_load  = 1'b1;
                s_load  = 1'b1;
                p_drive = !p_oe_n;
                s_drive = !s_oe_n;
                bus_vld = !p_oe_n || !s_oe_n;
            end
        end else if (p_ie_n_q ^ s_ie_n_q) begin
            op      = we_n_q ? OP_STREAM : OP_WRITE;
            wr_en   = !we_n_q;
            bus_vld = 1'b1;
            if (!p_ie_n_q) begin
                src     = SRC_PPORT;
                s_load  = 1'b1;
                s_drive = !s_oe_n;
            end else begin
                src     = SRC_SPORT;
                p_load  = 1'b1;
                p_drive = !p_oe_n;
            end
        end
    end

endmodule

// File: rtl/dbsram_array.sv
// Storage array of 2^ADDR_W words. The read is combinational from the held
// address. The write lands on the falling edge that closes the access. The
// contents are not reset.
module dbsram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Self-timed write at the end of the clock-high phase.
    always_ff @(negedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Read port for the current access.
    assign rdata = mem[addr];

endmodule

// File: rtl/dbsram_port_latch.sv
// Port output latch. It is open while the clock is high and this port is
// the target of the current access, and it holds otherwise. It is cleared by
// the synchronous reset while that reset is low.
module dbsram_port_latch #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Level-sensitive capture of the internal bus.
    always_latch begin
        if (!rst_n) begin
            q <= '0;
        end else if (clk && load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dbsram_top.sv
// Dual-bus synchronous SRAM with separate processor and system ports. It
// ties together capture, decode, array and the two port latches, and it
// drives the internal bus that the parity checker samples. It assumes that
// the output enables are stable around the rising edge that starts an access.
module dbsram_top
    import dbsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              we_n,
    input  logic              p_ie_n,
    input  logic              s_ie_n,
    input  logic              p_oe_n,
    input  logic              s_oe_n,
    input  logic [DATA_W-1:0] p_din,
    input  logic [DATA_W-1:0] s_din,
    output logic [DATA_W-1:0] p_dout,
    output logic              p_drive,
    output logic [DATA_W-1:0] s_dout,
    output logic              s_drive,
    output logic [DATA_W-1:0] ibus,
    output logic              ibus_vld,
    output logic              mode_err
);

    localparam int NPORT = 2;

    logic [ADDR_W-1:0] addr_q;
    logic              sel_q, we_n_q, p_ie_n_q, s_ie_n_q, bad_q;
    logic [DATA_W-1:0] p_din_q, s_din_q, rdata;
    op_e               op;
    src_e              src;
    logic              wr_en, p_load, s_load;
    logic [NPORT-1:0]  lat_load;
    logic [DATA_W-1:0] lat_q [NPORT];

    dbsram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
        .we_n(we_n), .p_ie_n(p_ie_n), .s_ie_n(s_ie_n),
        .p_oe_n(p_oe_n), .s_oe_n(s_oe_n), .p_din(p_din), .s_din(s_din),
        .addr_q(addr_q), .sel_q(sel_q), .we_n_q(we_n_q),
        .p_ie_n_q(p_ie_n_q), .s_ie_n_q(s_ie_n_q),
        .p_din_q(p_din_q), .s_din_q(s_din_q),
        .bad_q(bad_q), .mode_err(mode_err)
    );

    dbsram_decode u_dec (
        .sel_q(sel_q), .bad_q(bad_q), .we_n_q(we_n_q),
        .p_ie_n_q(p_ie_n_q), .s_ie_n_q(s_ie_n_q),
        .p_oe_n(p_oe_n), .s_oe_n(s_oe_n),
        .op(op), .src(src), .wr_en(wr_en),
        .p_load(p_load), .s_load(s_load),
        .p_drive(p_drive), .s_drive(s_drive), .bus_vld(ibus_vld)
    );

    // Internal bus source select.
    always_comb begin
        case (src)
            SRC_ARRAY: ibus = rdata;
            SRC_PPORT: ibus = p_din_q;
            SRC_SPORT: ibus = s_din_q;
            default:   ibus = '0;
        endcase
    end

    dbsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .wr_en(wr_en), .addr(addr_q), .wdata(ibus), .rdata(rdata)
    );

    assign lat_load = {s_load, p_load};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dbsram_port_latch #(.DATA_W(DATA_W)) u_lat (
            .clk(clk), .rst_n(rst_n), .load(lat_load[g]),
            .d(ibus), .q(lat_q[g])
        );
    end

    assign p_dout = lat_q[0];
    assign s_dout = lat_q[1];

endmodule

// File: rtl/dbsram_chk.sv
// Property checker for dbsram_top, attached by bind. Most properties are
// sampled at the falling edge, so they see the settled clock-high phase.
module dbsram_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_q,
    input logic              we_n_q,
    input logic              p_ie_n_q,
    input logic              s_ie_n_q,
    input logic              bad_q,
    input logic              wr_en,
    input logic              p_drive,
    input logic              s_drive,
    input logic [DATA_W-1:0] p_dout,
    input logic [DATA_W-1:0] s_dout,
    input logic [DATA_W-1:0] ibus,
    input logic              ibus_vld,
    input logic              mode_err
);

    // R3
    deselect_quiet_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !sel_q |-> (!p_drive && !s_drive && !ibus_vld && !wr_en));

    // R7
    p_in_blocks_out_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !p_ie_n_q |-> !p_drive);

    // R7
    s_in_blocks_out_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !s_ie_n_q |-> !s_drive);

    // R5
    write_one_source_chk: assert property (@(negedge clk) disable iff (!rst_n)
        wr_en |-> (!we_n_q && (p_ie_n_q != s_ie_n_q)));

    // R10
    refused_silent_chk: assert property (@(negedge clk) disable iff (!rst_n)
        bad_q |-> (!p_drive && !s_drive && !wr_en));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    // R11
    p_out_matches_bus_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (p_drive && ibus_vld) |-> (p_dout == ibus));

    // R11
    s_out_matches_bus_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (s_drive && ibus_vld) |-> (s_dout == ibus));

endmodule

bind dbsram_top dbsram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .we_n_q(we_n_q),
    .p_ie_n_q(p_ie_n_q), .s_ie_n_q(s_ie_n_q), .bad_q(bad_q),
    .wr_en(wr_en), .p_drive(p_drive), .s_drive(s_drive),
    .p_dout(p_dout), .s_dout(s_dout), .ibus(ibus),
    .ibus_vld(ibus_vld), .mode_err(mode_err)
);

// File: tb/tb_dbsram_top.sv
// Bench for dbsram_top. A vector is driven 7 ns after a rising edge, its
// address is taken at the next falling edge and its controls at the following
// rising edge, and its outputs are compared 4 ns after that edge against a
// behavioural model.
module tb_dbsram_top;

    localparam int AW = 10;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          sel_n, sel, we_n, p_ie_n, s_ie_n, p_oe_n, s_oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] pd, sd;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sel_n = 1'b1, sel = 1'b0, we_n = 1'b1, p_ie_n = 1'b1, s_ie_n = 1'b1;
    logic p_oe_n = 1'b1, s_oe_n = 1'b1;
    logic [DW-1:0] p_din = '0, s_din = '0;
    logic [DW-1:0] p_dout, s_dout, ibus;
    logic p_drive, s_drive, ibus_vld, mode_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] mdl [int];
    bit   err_m = 1'b0;
    bit   have_pend = 1'b0;
    vec_t pend;
    bit   pend_flip;
    string pend_tag;

    dbsram_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
        .we_n(we_n), .p_ie_n(p_ie_n), .s_ie_n(s_ie_n),
        .p_oe_n(p_oe_n), .s_oe_n(s_oe_n), .p_din(p_din), .s_din(s_din),
        .p_dout(p_dout), .p_drive(p_drive), .s_dout(s_dout), .s_drive(s_drive),
        .ibus(ibus), .ibus_vld(ibus_vld), .mode_err(mode_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic vec_t mk(bit sn, bit s, bit w, bit pi, bit si, bit po, bit so,
                                int a, int pdv, int sdv);
        vec_t v;
        v.sel_n = sn; v.sel = s; v.we_n = w; v.p_ie_n = pi; v.s_ie_n = si;
        v.p_oe_n = po; v.s_oe_n = so;
        v.addr = AW'(a); v.pd = DW'(pdv); v.sd = DW'(sdv);
        return v;
    endfunction

    // Model one access and compare it against the ports.
    task automatic compare(input vec_t v, input bit flip, input string tag);
        bit selv, bad, allow_p, allow_s, e_pd, e_sd, e_vld, known, wr;
        logic [DW-1:0] e_bus;
        selv = !v.sel_n && v.sel;
        bad = selv && (v.p_ie_n ^ v.s_ie_n) &&
              ((!v.p_ie_n && !v.p_oe_n) || (!v.s_ie_n && !v.s_oe_n));
        allow_p = 0; allow_s = 0; e_vld = 0; known = 1; wr = 0; e_bus = '0;
        if (selv && !bad) begin
            if (v.p_ie_n && v.s_ie_n && v.we_n) begin
                allow_p = 1; allow_s = 1;
                e_vld = !v.p_oe_n || !v.s_oe_n;
                known = mdl.exists(int'(v.addr));
                if (known) e_bus = mdl[int'(v.addr)];
            end else if (v.p_ie_n ^ v.s_ie_n) begin
                e_vld = 1;
                e_bus = !v.p_ie_n ? v.pd : v.sd;
                allow_s = !v.p_ie_n;
                allow_p = !v.s_ie_n;
                wr = !v.we_n;
            end
        end
        if (bad) err_m = 1'b1;
        e_pd = allow_p && !v.p_oe_n;
        e_sd = allow_s && !v.s_oe_n;
        chk(tag, "p_drive", DW'(p_drive), DW'(e_pd));
        chk(tag, "s_drive", DW'(s_drive), DW'(e_sd));
        chk("R11", "ibus_vld", DW'(ibus_vld), DW'(e_vld));
        chk("R10", "mode_err", DW'(mode_err), DW'(err_m));
        if (e_vld && known) chk("R11", "ibus", ibus, e_bus);
        if (e_pd && known) chk(tag, "p_dout", p_dout, e_bus);
        if (e_sd && known) chk(tag, "s_dout", s_dout, e_bus);
        if (flip) begin
            p_oe_n = ~p_oe_n;
            #1;
            chk("R9", "p_drive after mid-phase enable change",
                DW'(p_drive), DW'(allow_p && !p_oe_n));
            p_oe_n = ~p_oe_n;
        end else begin
            #1;
        end
        if (wr) mdl[int'(v.addr)] = e_bus;
    endtask

    // One cycle: compare the pending access, then drive the next vector.
    task automatic step(input vec_t v, input bit flip, input string tag);
        @(posedge clk);
        #4;
        if (have_pend) compare(pend, pend_flip, pend_tag);
        else #1;
        #2;
        sel_n = v.sel_n; sel = v.sel; we_n = v.we_n;
        p_ie_n = v.p_ie_n; s_ie_n = v.s_ie_n;
        p_oe_n = v.p_oe_n; s_oe_n = v.s_oe_n;
        addr = v.addr; p_din = v.pd; s_din = v.sd;
        pend = v; pend_flip = flip; pend_tag = tag; have_pend = 1'b1;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        vec_t idle;
        idle = mk(1, 0, 1, 1, 1, 1, 1, 0, 0, 0);
        repeat (3) @(posedge clk);
        #7 rst_n = 1'b1;
        @(posedge clk);
        #4;
        // R12 reset state
        chk("R12", "p_drive", DW'(p_drive), '0);
        chk("R12", "s_drive", DW'(s_drive), '0);
        chk("R12", "ibus_vld", DW'(ibus_vld), '0);
        chk("R12", "mode_err", DW'(mode_err), '0);

        // Writes from each port (R5, R7: source port with enable high stays quiet)
        step(mk(0, 1, 0, 0, 1, 1, 1, 5, 9'h1A5, 9'h000), 0, "R7");
        step(mk(0, 1, 0, 1, 0, 1, 1, 6, 9'h000, 9'h05A), 0, "R5");
        // Reads: both ports, each port, mid-phase enable change (R4, R9)
        step(mk(0, 1, 1, 1, 1, 0, 0, 5, 0, 0), 0, "R4");
        step(mk(0, 1, 1, 1, 1, 0, 1, 6, 0, 0), 1, "R9");
        step(mk(0, 1, 1, 1, 1, 1, 0, 6, 0, 0), 0, "R4");
        step(mk(0, 1, 1, 1, 1, 1, 1, 6, 0, 0), 1, "R9");
        // Deselect by either select, with write attempts (R3)
        step(mk(1, 1, 0, 0, 1, 1, 1, 5, 9'h000, 0), 0, "R3");
        step(mk(0, 0, 0, 1, 0, 0, 0, 6, 0, 9'h1FF), 0, "R3");
        step(mk(0, 1, 1, 1, 1, 0, 0, 5, 0, 0), 0, "R3");
        step(mk(0, 1, 1, 1, 1, 0, 0, 6, 0, 0), 0, "R3");
        // NOP combinations (R6)
        step(mk(0, 1, 0, 0, 0, 1, 1, 5, 9'h011, 9'h022), 0, "R6");
        step(mk(0, 1, 1, 0, 0, 0, 0, 5, 9'h011, 9'h022), 0, "R6");
        step(mk(0, 1, 0, 1, 1, 0, 0, 5, 9'h033, 9'h044), 0, "R6");
        step(mk(0, 1, 1, 1, 1, 0, 0, 5, 0, 0), 0, "R6");
        // Write-through and stream-only (R8)
        step(mk(0, 1, 0, 0, 1, 1, 0, 7, 9'h133, 0), 0, "R8");
        step(mk(0, 1, 1, 1, 0, 0, 1, 5, 0, 9'h0FF), 0, "R8");
        step(mk(0, 1, 1, 0, 1, 1, 0, 6, 9'h155, 0), 0, "R8");
        step(mk(0, 1, 1, 1, 1, 0, 0, 7, 0, 0), 0, "R8");
        step(mk(0, 1, 1, 1, 1, 0, 0, 5, 0, 0), 0, "R8");
        step(mk(0, 1, 1, 1, 1, 0, 1, 6, 0, 0), 0, "R8");
        // Refused combinations (R10): write attempts, then read back
        step(mk(0, 1, 0, 0, 1, 0, 1, 5, 9'h000, 0), 0, "R10");
        step(mk(0, 1, 0, 1, 0, 1, 0, 6, 0, 9'h000), 0, "R10");
        step(mk(0, 1, 1, 1, 1, 0, 0, 5, 0, 0), 0, "R10");
        step(mk(0, 1, 1, 1, 1, 0, 0, 6, 0, 0), 0, "R10");
        // Address sweep with boundaries, back-to-back (R1, R2)
        for (int i = 0; i < 16; i++) begin
            int a;
            a = (i == 15) ? DEPTH - 1 : (i * 67) % DEPTH;
            if (i % 2 == 0) step(mk(0, 1, 0, 0, 1, 1, 1, a, (i * 37 + 3) % 512, 0), 0, "R1");
            else            step(mk(0, 1, 0, 1, 0, 1, 1, a, 0, (i * 37 + 3) % 512), 0, "R1");
        end
        for (int i = 0; i < 16; i++) begin
            int a;
            a = (i == 15) ? DEPTH - 1 : (i * 67) % DEPTH;
            step(mk(0, 1, 1, 1, 1, i % 2, (i + 1) % 2, a, 0, 0), 0, "R1");
        end
        // Write then immediate read of the same word (R2)
        step(mk(0, 1, 0, 0, 1, 1, 1, 9, 9'h1C3, 0), 0, "R2");
        step(mk(0, 1, 1, 1, 1, 0, 0, 9, 0, 0), 0, "R2");
        step(mk(0, 1, 0, 1, 0, 1, 1, 9, 0, 9'h03C), 0, "R2");
        step(mk(0, 1, 1, 1, 1, 0, 0, 9, 0, 0), 0, "R2");
        step(idle, 0, "R3");
        step(idle, 0, "R3");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule